// File: doc/BRIEF.md
# PWM Time-Base Counter With Phase Synchronization

This block is the time base of a PWM channel. An up-counter advances once for every cycle in which the time-base enable is high. The enable is a prescaled tick in the module clock domain. After the counter reaches the programmed period it returns to zero. The block also accepts a synchronization event, which comes either from an external pulse or from a software write strobe. When phase locking is enabled, that event forces the counter to a programmed phase value. Several channels can be aligned to each other in this way.

Each time the counter arrives at zero through a time-base tick, the block emits a sync-out pulse one module clock wide. The pulse can drive the sync input of a downstream counter, so that a chain of channels follows one master. A sync event is held as pending until the next time-base tick, and the phase load happens on that tick. The latency is therefore two module clocks when the time base runs at full rate, and at most one time-base period when it is prescaled.

Top module: `pwm_phase_timebase`

## Requirements
- R1: While `rst` is high, and in the first cycle after it has been sampled high, `cnt` is 0 and `sync_out` is 0.
- R2: On a clock edge where `tb_en` is 1 and no phase load is due, `cnt` increases by 1 if it is below `period_val`. On an edge where `tb_en` is 0, `cnt` holds its value.
- R3: On a `tb_en` edge where `cnt` equals `period_val` and no phase load is due, `cnt` becomes 0.
- R4: With `phase_en` at 1 and `tb_en` held at 1, a `sync_in` level sampled high at edge k causes `cnt` to equal `phase_val` after edge k+1. That is a delay of 2 module clocks, and the tick at edge k still counts normally.
- R5: With a prescaled `tb_en`, a sync event sampled while `tb_en` is 0 is held. The load then replaces the normal count step at the first later edge where `tb_en` is 1.
- R6: While `phase_en` is 0, sync events from either source have no effect on `cnt`, and no pending event survives a cycle with `phase_en` at 0.
- R7: A rising edge of `swsync_wr` acts as exactly one sync event with the same timing as `sync_in`. Holding the strobe high for several cycles gives only one event.
- R8: When a phase load and a period wrap fall on the same `tb_en` edge, the counter takes `phase_val`.
- R9: A `phase_val` above `period_val` is loaded unchanged. The counter then counts up to 2^CNT_W-1 and then moves to 0.
- R10: `sync_out` is 1 for exactly the cycle after a `tb_en` edge that made `cnt` 0, by wrap, by overflow or by loading a zero phase. In any other cycle it is 0, including while a zero count is held with `tb_en` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_en | input | 1 | Time-base tick enable, one module clock wide per tick |
| phase_en | input | 1 | Lets sync events load the phase value |
| phase_val | input | CNT_W | Value loaded into the counter on a sync |
| period_val | input | CNT_W | Last count before the counter returns to 0 |
| sync_in | input | 1 | External synchronization pulse, sampled each clock |
| swsync_wr | input | 1 | Software force-sync write strobe; its rising edge counts |
| cnt | output | CNT_W | Time-base counter value |
| sync_out | output | 1 | One-clock pulse when the counter arrives at zero |

## Verification
The properties assume that `phase_val` and `period_val` do not change at the edge where they are used, and that `tb_en` is a single-clock tick or held high. The stimulus keeps both registers constant while the vector table is walked. It changes `phase_val` only after two idle ticks, and it always drives inputs on the falling clock edge. `sync_in` is treated as a level sampled every clock, so the bench asserts it for a single cycle wherever a single event is meant.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_INC,
        ACT_WRAP,
        ACT_LOAD
    } ptb_act_e;

    typedef struct packed {
        logic sw_pulse;
        logic event_seen;
        logic load_due;
    } ptb_sync_s;

    function automatic ptb_act_e ptb_pick_act(input logic tick,
                                              input logic load_due,
                                              input logic at_period);
        ptb_act_e act;
        if (!tick)
            act = ACT_HOLD;
        else if (load_due)
            act = ACT_LOAD;
        else if (at_period)
            act = ACT_WRAP;
        else
            act = ACT_INC;
        return act;
    endfunction

endpackage

// File: rtl/ptb_sync_gate.sv
module ptb_sync_gate
    import ptb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tb_en,
    input  logic      phase_en,
    input  logic      sync_in,
    input  logic      swsync_wr,
    output ptb_sync_s sync_st
);

    logic sw_prev;
    logic pend_q;
    logic pend_d;
    logic sw_pulse;
    logic evt;

    assign sw_pulse = swsync_wr & ~sw_prev;
    assign evt      = sync_in | sw_pulse;

    always_comb begin
        if (!phase_en)
            pend_d = 1'b0;
        else if (evt)
            pend_d = 1'b1;
        else if (tb_en)
            pend_d = 1'b0;
        else
            pend_d = pend_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_prev <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            sw_prev <= swsync_wr;
            pend_q  <= pend_d;
        end
    end

    assign sync_st.sw_pulse   = sw_pulse;
    assign sync_st.event_seen = evt;
    assign sync_st.load_due   = pend_q;

endmodule

// File: rtl/ptb_counter.sv
module ptb_counter
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tb_en,
    input  logic             load_due,
    input  logic [CNT_W-1:0] phase_val,
    input  logic [CNT_W-1:0] period_val,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    ptb_act_e act;

    always_comb begin
        act = ptb_pick_act(tb_en, load_due, cnt == period_val);
        case (act)
            ACT_LOAD: cnt_nxt = phase_val;
            ACT_WRAP: cnt_nxt = ZERO;
            ACT_INC:  cnt_nxt = cnt + ONE;
            default:  cnt_nxt = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= ZERO;
        else
            cnt <= cnt_nxt;
    end

endmodule

// File: rtl/ptb_zero_flag.sv
module ptb_zero_flag #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tb_en,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic             sync_out
);

    always_ff @(posedge clk) begin
        if (rst)
            sync_out <= 1'b0;
        else
            sync_out <= tb_en && (cnt_nxt == '0);
    end

endmodule

// File: rtl/pwm_phase_timebase.sv
module pwm_phase_timebase
    import ptb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tb_en,
    input  logic             phase_en,
    input  logic [CNT_W-1:0] phase_val,
    input  logic [CNT_W-1:0] period_val,
    input  logic             sync_in,
    input  logic             swsync_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             sync_out
);

    ptb_sync_s        sync_st;
    logic [CNT_W-1:0] cnt_nxt;
    logic             load_due;
    logic             sw_pulse;

    assign load_due = sync_st.load_due;
    assign sw_pulse = sync_st.sw_pulse;

    ptb_sync_gate u_sync (
        .clk       (clk),
        .rst       (rst),
        .tb_en     (tb_en),
        .phase_en  (phase_en),
        .sync_in   (sync_in),
        .swsync_wr (swsync_wr),
        .sync_st   (sync_st)
    );

    ptb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tb_en      (tb_en),
        .load_due   (load_due),
        .phase_val  (phase_val),
        .period_val (period_val),
        .cnt        (cnt),
        .cnt_nxt    (cnt_nxt)
    );

    ptb_zero_flag #(.CNT_W(CNT_W)) u_zero (
        .clk      (clk),
        .rst      (rst),
        .tb_en    (tb_en),
        .cnt_nxt  (cnt_nxt),
        .sync_out (sync_out)
    );

endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tb_en,
    input logic             phase_en,
    input logic [CNT_W-1:0] phase_val,
    input logic [CNT_W-1:0] period_val,
    input logic             load_due,
    input logic             sw_pulse,
    input logic [CNT_W-1:0] cnt,
    input logic             sync_out
);

    // R2: no tick, no movement
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tb_en |=> $stable(cnt));

    // R3: wrap at period when no load is due
    a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
        (tb_en && !load_due && cnt == period_val) |=> cnt == '0);

    // R4 / R8: a due load on a tick wins and lands the phase value
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (tb_en && load_due) |=> cnt == $past(phase_val));

    // R6: disabled phase locking leaves nothing pending
    a_r6_no_pend: assert property (@(posedge clk) disable iff (rst)
        !phase_en |=> !load_due);

    // R7: software pulse is one clock wide
    a_r7_sw_one: assert property (@(posedge clk) disable iff (rst)
        sw_pulse |=> !sw_pulse);

    // R10: sync-out only while the count is zero
    a_r10_zero: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> cnt == '0);

    // R10: no sync-out in a cycle following a cycle without a tick
    a_r10_tick: assert property (@(posedge clk) disable iff (rst)
        !tb_en |=> !sync_out);

endmodule

bind pwm_phase_timebase ptb_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tb_en      (tb_en),
    .phase_en   (phase_en),
    .phase_val  (phase_val),
    .period_val (period_val),
    .load_due   (load_due),
    .sw_pulse   (sw_pulse),
    .cnt        (cnt),
    .sync_out   (sync_out)
);

// File: tb/test_pwm_phase_timebase.sv
module test_pwm_phase_timebase;

    localparam int W = 8;
    localparam int NV = 26;

    logic         clk = 1'b0;
    logic         rst;
    logic         tb_en;
    logic         phase_en;
    logic [W-1:0] phase_val;
    logic [W-1:0] period_val;
    logic         sync_in;
    logic         swsync_wr;
    logic [W-1:0] cnt;
    logic         sync_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwm_phase_timebase #(.CNT_W(W)) i_pwm_phase_timebase (
        .clk        (clk),
        .rst        (rst),
        .tb_en      (tb_en),
        .phase_en   (phase_en),
        .phase_val  (phase_val),
        .period_val (period_val),
        .sync_in    (sync_in),
        .swsync_wr  (swsync_wr),
        .cnt        (cnt),
        .sync_out   (sync_out)
    );

    // {req, tb_en sync_in swsync_wr phase_en, expected cnt, expected sync_out}
    // phase_val = 2, period_val = 3 throughout the table
    localparam logic [16:0] VECS [0:NV-1] = '{
        {4'd2,  4'b1001, 8'd1, 1'b0},  // R2 count
        {4'd2,  4'b1001, 8'd2, 1'b0},
        {4'd2,  4'b1001, 8'd3, 1'b0},
        {4'd3,  4'b1001, 8'd0, 1'b1},  // R3 wrap
        {4'd10, 4'b0001, 8'd0, 1'b0},  // R10 one wide, R2 hold
        {4'd2,  4'b1001, 8'd1, 1'b0},
        {4'd4,  4'b1101, 8'd2, 1'b0},  // R4 sync tick counts
        {4'd4,  4'b1001, 8'd2, 1'b0},  // R4 load two clocks later
        {4'd4,  4'b1001, 8'd3, 1'b0},
        {4'd10, 4'b1001, 8'd0, 1'b1},
        {4'd5,  4'b0101, 8'd0, 1'b0},  // R5 sync between ticks
        {4'd5,  4'b0001, 8'd0, 1'b0},
        {4'd5,  4'b1001, 8'd2, 1'b0},  // R5 load on next tick
        {4'd5,  4'b1001, 8'd3, 1'b0},
        {4'd3,  4'b1101, 8'd0, 1'b1},
        {4'd4,  4'b1001, 8'd2, 1'b0},
        {4'd8,  4'b1101, 8'd3, 1'b0},
        {4'd8,  4'b1001, 8'd2, 1'b0},  // R8 load beats wrap
        {4'd6,  4'b1100, 8'd3, 1'b0},  // R6 disabled
        {4'd6,  4'b1000, 8'd0, 1'b1},
        {4'd6,  4'b1000, 8'd1, 1'b0},
        {4'd7,  4'b1011, 8'd2, 1'b0},  // R7 strobe rises
        {4'd7,  4'b1011, 8'd2, 1'b0},
        {4'd7,  4'b1011, 8'd3, 1'b0},  // R7 held strobe: no second event
        {4'd7,  4'b1001, 8'd0, 1'b1},
        {4'd2,  4'b1001, 8'd1, 1'b0}
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp_cnt,
                         input logic exp_so);
        checks++;
        if (cnt !== exp_cnt || sync_out !== exp_so) begin
            fails++;
            $display("FAIL %s: cnt=%0d sync_out=%0b expected cnt=%0d sync_out=%0b",
                     req, cnt, sync_out, exp_cnt, exp_so);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        rst        = 1'b1;
        tb_en      = 1'b1;
        phase_en   = 1'b1;
        phase_val  = 8'd2;
        period_val = 8'd3;
        sync_in    = 1'b1;
        swsync_wr  = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", 8'd0, 1'b0);  // R1 reset state
        rst     = 1'b0;
        sync_in = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {tb_en, sync_in, swsync_wr, phase_en} = VECS[i][12:9];
            @(negedge clk);
            check(req_name(VECS[i][16:13]), VECS[i][8:1], VECS[i][0]);
        end

        // R9: phase above period
        tb_en     = 1'b1;
        sync_in   = 1'b0;
        swsync_wr = 1'b0;
        phase_en  = 1'b1;
        @(negedge clk);
        @(negedge clk);
        phase_val = 8'd200;
        sync_in   = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        @(negedge clk);
        check("R9", 8'd200, 1'b0);
        repeat (55) @(negedge clk);
        check("R9", 8'd255, 1'b0);
        @(negedge clk);
        check("R9", 8'd0, 1'b1);  // overflow to zero, R10 pulse

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", 8'd0, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        finish_run();
    end

endmodule